// File: doc/BRIEF.md
# Register-Write Serial Control Slave

This block is a two-wire serial bus slave that accepts write transfers from a bus master and stores the received bytes in an internal bank of control registers. It oversamples the clock and data lines with a fast system clock, finds bus start and stop events, and compares the first byte with its own 7-bit bus address. That address is a fixed five-bit prefix followed by two strap inputs. It acknowledges each byte it accepts by pulling the data line low during the ninth clock.

After a matching address with the write direction, the next byte is a register pointer. Every byte after that is stored at the pointer, and the pointer then advances. The bank holds registers 0x00 to 0x1C, so the pointer wraps from 0x1C to 0x00 and not at a power of two. Read requests, foreign addresses and malformed pointer bytes are left unacknowledged, and the slave stays silent until the next start. The register contents come out as one flat vector, and the data-line pull-down comes out as an open-drain enable.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset every register reads 0x00 and the SDA pull-down enable is 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop releases SDA. A start in the middle of a transfer restarts address reception, and no pointer or data byte is taken from the abandoned part.
- R3: The first byte is seven address bits, MSB first, then a direction bit where 0 means write. When the address equals 0b00100 followed by strap_i[1:0] and the direction bit is 0, the slave holds SDA low through the ninth SCL high period.
- R4: When the address differs, the slave does not acknowledge, writes nothing and keeps SDA released until the next start.
- R5: A matching address with the direction bit set to 1 (read) is not acknowledged, and no register changes.
- R6: The second byte is the register pointer, MSB first. When its top three bits are zero it is acknowledged and loads the pointer with its value.
- R7: A pointer byte with any of its top three bits set is not acknowledged, and the data bytes that follow are ignored.
- R8: Each byte after the pointer is acknowledged and stored MSB first at the pointer. The pointer then advances by one, so consecutive bytes fill consecutive registers.
- R9: A data byte stored at 0x1C moves the pointer to 0x00, so later bytes overwrite registers from 0x00 upward.
- R10: When the pointer is 0x1D to 0x1F, a data byte is acknowledged but stored nowhere, and the pointer moves to 0x00.
- R11: The SDA pull-down enable only changes while SCL is low, and it stays constant across the whole SCL high period of an acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Strap pins that supply the two low address bits |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open-drain enable) |
| regs_o | output | 232 | Register bank, with register n at bits [8n+7:8n] |

## Verification
Every combination of the strap setting and the address low bits is tried, so only the exact address acknowledges, and each transfer also lands a byte whose position shows whether the pointer was taken. One burst writes the whole 29-entry bank with arithmetic values, which separates a correct increment from a stuck or skipping pointer. Further bursts start at 0x1A and at 0x1E, and their values tell a wrap at 0x1C apart from a wrap at 0x1F or 0x3F. Read requests, a pointer byte with high bits set and a repeated start must each leave the bank unchanged, apart from the one byte written after the restart.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_PTR  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  // Bus events are only meaningful while the clock line stays high.
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regwr_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          PTR_W      = 6,
  parameter int          STRAP_W    = 2,
  parameter int          ADDR_W     = 7,
  parameter int          REG_LAST   = 28,
  parameter int          PTR_FREE_W = 5,
  parameter logic [ADDR_W-STRAP_W-1:0] PREFIX = 5'b00100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               wr_en_o,
  output logic [PTR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);

  localparam int          CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DATA_W);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(REG_LAST);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  shreg_q;
  logic               ack_ph_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               addr_hit;
  logic               ptr_ok;
  logic [PTR_W-1:0]   ptr_next;

  assign addr_hit = (shreg_q == {PREFIX, strap_i, 1'b0});
  assign ptr_ok   = (shreg_q[DATA_W-1:PTR_FREE_W] == '0);
  assign ptr_next = (ptr_q >= LAST_PTR) ? '0 : ptr_q + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_o  <= 1'b0;
      ptr_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        phase_q  <= PH_ADDR;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise && !ack_ph_q && cnt_q != BYTE_DONE) begin
          shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
          cnt_q   <= cnt_q + CNT_W'(1);
        end else if (scl_fall) begin
          if (ack_ph_q) begin
            sda_oe_o <= 1'b0;
            ack_ph_q <= 1'b0;
            cnt_q    <= '0;
          end else if (cnt_q == BYTE_DONE) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (addr_hit) begin
                  sda_oe_o <= 1'b1;
                  ack_ph_q <= 1'b1;
                  phase_q  <= PH_PTR;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              PH_PTR: begin
                if (ptr_ok) begin
                  ptr_q    <= shreg_q[PTR_W-1:0];
                  sda_oe_o <= 1'b1;
                  ack_ph_q <= 1'b1;
                  phase_q  <= PH_DATA;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              PH_DATA: begin
                sda_oe_o <= 1'b1;
                ack_ph_q <= 1'b1;
                if (ptr_q <= LAST_PTR) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= shreg_q;
                end
                ptr_q <= ptr_next;
              end
              default: phase_q <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R11: the pull-down is only switched on while the clock line is low
  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_s);

  // R2: a stop leaves the data line released
  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  // R4: an idle slave never drives the data line
  assert_idle_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !sda_oe_o);

  // R9: a byte stored at the last register leaves the pointer at zero
  assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == LAST_PTR) |-> (ptr_q == '0));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREG   = 29,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] regs_o
);

  logic [DATA_W-1:0] bank_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (wr_en && int'(wr_addr) < NREG) begin
      bank_q[wr_addr] <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign regs_o[g*DATA_W +: DATA_W] = bank_q[g];
    end
  endgenerate

  // R10: the controller never issues a store outside the bank
  assert_store_in_map_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < NREG));

  // R8: a store lands in the addressed register one cycle later
  assert_store_lands_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (bank_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave #(
  parameter int DATA_W      = 8,
  parameter int PTR_W       = 6,
  parameter int STRAP_W     = 2,
  parameter int ADDR_W      = 7,
  parameter int REG_LAST    = 28,
  parameter int PTR_FREE_W  = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] PREFIX = 5'b00100
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                scl_i,
  input  logic                                sda_i,
  input  logic [STRAP_W-1:0]                  strap_i,
  output logic                                sda_oe_o,
  output logic [(REG_LAST+1)*DATA_W-1:0]      regs_o
);

  localparam int NREG = REG_LAST + 1;

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_slave_fsm #(
    .DATA_W     (DATA_W),
    .PTR_W      (PTR_W),
    .STRAP_W    (STRAP_W),
    .ADDR_W     (ADDR_W),
    .REG_LAST   (REG_LAST),
    .PTR_FREE_W (PTR_FREE_W),
    .PREFIX     (PREFIX)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap_i   (strap_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  i2c_reg_bank #(
    .NREG   (NREG),
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs_o)
  );

endmodule

// File: tb/i2c_regwr_slave_test.sv
module i2c_regwr_slave_test;

  localparam int NREG = 29;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] expv [NREG];
  logic [7:0] wbuf [32];

  always #5 clk = ~clk;

  i2c_regwr_slave uut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
    check(sda_oe == 1'b0, "R2 release after stop", int'(sda_oe), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    logic oe_pre, oe_mid;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1; tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    oe_pre = sda_oe;
    scl = 1'b1; tick(Q/2);
    got_ack = ~sda_bus;
    oe_mid = sda_oe;
    tick(Q/2);
    check(oe_pre == oe_mid, "R11 drive stable in high clock", int'(oe_mid), int'(oe_pre));
    scl = 1'b0; tick(Q);
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++)
      check(regs[i*8 +: 8] == expv[i], req, int'(regs[i*8 +: 8]), int'(expv[i]));
  endtask

  // Full write transfer with expected acks and a mirrored bank
  task automatic write_txn(input logic [7:0] abyte, input logic [7:0] ptr, input int n);
    logic a;
    bit   live;
    int   p;
    live = (abyte == {5'b00100, strap, 1'b0});
    bus_start();
    send_byte(abyte, a);
    check(a == live, (abyte[0] ? "R5 read not acked" : (live ? "R3 address ack" : "R4 mismatch no ack")),
          int'(a), int'(live));
    send_byte(ptr, a);
    if (live) check(a == (ptr[7:5] == 3'b0), (ptr[7:5] == 3'b0) ? "R6 pointer ack" : "R7 bad pointer nack",
                    int'(a), int'(ptr[7:5] == 3'b0));
    else check(a == 1'b0, "R4 silent after mismatch", int'(a), 0);
    live = live && (ptr[7:5] == 3'b0);
    p = int'(ptr);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      check(a == live, (p > 28) ? "R10 out-of-map byte acked" : "R8 data ack", int'(a), int'(live));
      if (live) begin
        if (p <= 28) expv[p] = wbuf[k];
        p = (p >= 28) ? 0 : p + 1;
      end
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    for (int i = 0; i < NREG; i++) expv[i] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);
    check_bank("R1 reset value");

    // R3 / R4: every strap setting against every address low-bit pair
    for (int s = 0; s < 4; s++) begin
      for (int lo = 0; lo < 4; lo++) begin
        strap = 2'(s);
        wbuf[0] = 8'(8'h40 + s*4 + lo);
        write_txn({5'b00100, 2'(lo), 1'b0}, 8'(lo*4 + s), 1);
      end
    end
    check_bank("R3 R4 strap sweep contents");
    // wrong prefix with matching low bits
    strap = 2'd1;
    wbuf[0] = 8'hEE;
    write_txn({5'b00101, 2'd1, 1'b0}, 8'h02, 1);
    check_bank("R4 wrong prefix no write");

    // R5: read direction is ignored
    wbuf[0] = 8'h99;
    write_txn({5'b00100, 2'd1, 1'b1}, 8'h03, 1);
    check_bank("R5 read leaves bank");

    // R8: whole bank in one burst
    for (int k = 0; k < NREG; k++) wbuf[k] = 8'(k*37 + 11);
    write_txn({5'b00100, 2'd1, 1'b0}, 8'h00, NREG);
    check_bank("R8 burst fill");

    // R9: wrap from 0x1C to 0x00
    for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'hC0 + k);
    write_txn({5'b00100, 2'd1, 1'b0}, 8'h1A, 5);
    check(regs[0*8 +: 8] == 8'hC3, "R9 wrap lands at 0x00", int'(regs[7:0]), 8'hC3);
    check_bank("R9 wrap contents");

    // R10: pointer beyond map
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA7;
    write_txn({5'b00100, 2'd1, 1'b0}, 8'h1E, 2);
    check(regs[0*8 +: 8] == 8'hA7, "R10 next byte at 0x00", int'(regs[7:0]), 8'hA7);
    check_bank("R10 out-of-map contents");

    // R7: pointer with high bits set
    wbuf[0] = 8'h11;
    write_txn({5'b00100, 2'd1, 1'b0}, 8'h25, 1);
    check_bank("R7 bad pointer no write");

    // R2: repeated start mid-transfer
    bus_start();
    send_byte({5'b00100, 2'd1, 1'b0}, a);
    check(a == 1'b1, "R2 first address ack", int'(a), 1);
    send_byte(8'h03, a);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
    send_byte({5'b00100, 2'd1, 1'b0}, a);
    check(a == 1'b1, "R2 address after restart acked", int'(a), 1);
    send_byte(8'h08, a);
    send_byte(8'hA5, a);
    bus_stop();
    expv[8] = 8'hA5;
    check(regs[8*8 +: 8] == 8'hA5, "R2 restart write at 0x08", int'(regs[8*8 +: 8]), 8'hA5);
    check_bank("R2 restart contents");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule